// File: doc/BRIEF.md
# Pipelined Secondary Cache Read Path

This block is the read side of an off-chip secondary cache built from a tag RAM and a data SRAM. It accepts one read request per clock and returns one response per request, exactly five clocks later, in the order the requests arrived. The tag RAM and the data SRAM are modelled inside the block as synchronous arrays, each with one clock of access time.

The five stages are fixed. The first launches the address toward the tag RAM, and the second performs the tag lookup and the tag compare. The third stage does no work: it only carries the tag side results across to the data array. The fourth stage reads the data array, and the fifth drives the response. Every stage carries a valid bit, so a cycle without a request leaves a bubble that produces no response.

A separate fill port writes a tag, its valid bit and a data word into one index. Refill sequencing, write policy and coherence belong to other blocks.

Top module: `ext_cache_pipe`

## Requirements
- R1: A request presented with `req_valid` high in clock n produces `rsp_valid` high in clock n+5, and not before.
- R2: Requests may arrive on every clock. Responses for back-to-back requests come out on consecutive clocks, in request order.
- R3: A clock with `req_valid` low produces no response five clocks later.
- R4: The address is split into an index, which is `req_addr[IDX_W-1:0]`, and a tag, which is the remaining upper bits. A response is a hit (`rsp_hit` = 1) when the entry at that index is valid and its stored tag equals the request tag.
- R5: A response is a miss (`rsp_hit` = 0) when the indexed entry is invalid or its tag differs, and a miss response carries `rsp_data` = 0.
- R6: A hit response carries the data word written by the most recent fill to that index.
- R7: A fill presented in clock n is seen by a request presented in clock n+1.
- R8: Reset marks every entry invalid and empties the pipeline. No response appears until a request is accepted, and the first requests after reset all miss.
- R9: While `rsp_valid` is low, `rsp_hit` and `rsp_data` are 0.
- R10: A fill to an index replaces that index's previous tag, so requests that carry the old tag miss afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present this clock |
| req_addr | input | ADDR_W | Read word address (tag in the upper bits, index in the lower bits) |
| fill_en | input | 1 | Write one entry this clock |
| fill_addr | input | ADDR_W | Address whose index and tag the fill stores |
| fill_data | input | DATA_W | Data word stored by the fill |
| rsp_valid | output | 1 | Response present this clock |
| rsp_hit | output | 1 | Response hit flag |
| rsp_data | output | DATA_W | Response data, 0 on a miss |

## Verification
The bench tracks the exact clock in which each response is due. A design that drops or adds a register, for example by skipping the empty carry stage, fails on latency, and one that ignores the valid bit produces a response in a bubble cycle. Fills are followed directly by a request to the same index, so a fill that is one clock late shows up as a miss. An index is also refilled with a new tag and then probed with both its old and its new address, so a tag compare that ignores the upper bits or a stale tag read reports a hit where a miss is due. The tests also cover the first requests after reset, the highest index combined with an all-ones tag, and the data on miss responses, which would show leaked array contents.

// File: rtl/xc_pkg.sv
// Package: shared defaults and stage control type for the external cache read path.
// Assumes: consumers derive all widths from their own parameters; these are defaults only.
package xc_pkg;
    localparam int XC_ADDR_W = 16;
    localparam int XC_IDX_W  = 6;
    localparam int XC_DATA_W = 32;

    // Control bits that ride along with each request through the pipeline.
    typedef struct packed {
        logic vld;
        logic hit;
    } xc_ctl_t;
endpackage

// File: rtl/xc_tag_ram.sv
// Module: synchronous tag array with one valid bit per entry.
// What it does: returns the stored tag and valid bit one clock after the index is applied.
// Assumes: one read and one write per clock; a read and a write to the same index in the
// same clock return the old contents. The valid bits clear on reset; the tags do not.
module xc_tag_ram #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [DEPTH-1:0] vld_mem;

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_mem <= '0;
        else if (wr_en) vld_mem[wr_idx] <= 1'b1;
    end

    // Tag storage: written by a fill, no reset.
    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end

    // Registered read port: one clock of access time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
            rd_tag <= '0;
        end else begin
            rd_vld <= vld_mem[rd_idx];
            rd_tag <= tag_mem[rd_idx];
        end
    end
endmodule

// File: rtl/xc_data_ram.sv
// Module: synchronous data array.
// What it does: returns the stored word one clock after the index is applied.
// Assumes: one read and one write per clock; the contents are undefined until filled,
// and the consumer gates the output with its hit flag.
module xc_data_ram #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] data_mem [DEPTH];

    // Data storage: written by a fill.
    always_ff @(posedge clk) begin
        if (wr_en) data_mem[wr_idx] <= wr_data;
    end

    // Registered read port: one clock of access time.
    always_ff @(posedge clk) begin
        rd_data <= data_mem[rd_idx];
    end
endmodule

// File: rtl/ext_cache_pipe.sv
// Module: five-stage read pipeline for an external tag RAM plus data SRAM cache.
// What it does: stage 1 launches the address, stage 2 reads the tags and compares them,
// stage 3 only carries the results toward the data array, stage 4 reads the data, and
// stage 5 registers the response. The latency is fixed at five clocks, and every request
// gets its own response.
// Assumes: fills are not issued while an earlier request to the same index is still in
// flight. A fill is visible to requests presented from the following clock on.
module ext_cache_pipe #(
    parameter int ADDR_W = xc_pkg::XC_ADDR_W,
    parameter int IDX_W  = xc_pkg::XC_IDX_W,
    parameter int DATA_W = xc_pkg::XC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);
    import xc_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W;

    // Stage 1: address launch toward the tag RAM.
    logic              s1_vld;
    logic [ADDR_W-1:0] s1_addr;
    // Stage 2: tag lookup and compare.
    logic              s2_vld;
    logic [TAG_W-1:0]  s2_tag;
    logic [IDX_W-1:0]  s2_idx;
    logic [TAG_W-1:0]  tr_tag;
    logic              tr_vld;
    logic              s2_hit;
    // Stage 3: propagation only.
    xc_ctl_t           s3_ctl;
    logic [IDX_W-1:0]  s3_idx;
    // Stage 4: data read.
    xc_ctl_t           s4_ctl;
    logic [DATA_W-1:0] dr_data;

    // Stage 1 register: capture the request and launch its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_vld  <= req_valid;
            s1_addr <= req_addr;
        end
    end

    xc_tag_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (s1_addr[IDX_W-1:0]),
        .rd_tag (tr_tag),
        .rd_vld (tr_vld),
        .wr_en  (fill_en),
        .wr_idx (fill_addr[IDX_W-1:0]),
        .wr_tag (fill_addr[ADDR_W-1:IDX_W])
    );

    // Stage 2 register: move the request alongside the tag RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_tag <= '0;
            s2_idx <= '0;
        end else begin
            s2_vld <= s1_vld;
            s2_tag <= s1_addr[ADDR_W-1:IDX_W];
            s2_idx <= s1_addr[IDX_W-1:0];
        end
    end

    // Tag compare at the end of stage 2.
    always_comb begin
        s2_hit = tr_vld && (tr_tag == s2_tag);
    end

    // Stage 3 register: carry the hit flag and the data index across; no logic here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_ctl <= '0;
            s3_idx <= '0;
        end else begin
            s3_ctl.vld <= s2_vld;
            s3_ctl.hit <= s2_vld && s2_hit;
            s3_idx     <= s2_idx;
        end
    end

    xc_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (s3_idx),
        .rd_data (dr_data),
        .wr_en   (fill_en),
        .wr_idx  (fill_addr[IDX_W-1:0]),
        .wr_data (fill_data)
    );

    // Stage 4 register: control travels beside the data array read.
    always_ff @(posedge clk) begin
        if (!rst_n) s4_ctl <= '0;
        else        s4_ctl <= s3_ctl;
    end

    // Stage 5 register: drive the response; the data is forced to zero unless it is a valid hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= s4_ctl.vld;
            rsp_hit   <= s4_ctl.vld && s4_ctl.hit;
            rsp_data  <= (s4_ctl.vld && s4_ctl.hit) ? dr_data : '0;
        end
    end
endmodule

// File: rtl/xc_pipe_checker.sv
// Module: protocol checker for ext_cache_pipe, attached by bind.
// What it does: checks the response timing and the quiet-output rules at the ports.
// Assumes: synchronous active-low reset; counts clocks since reset so that no history
// check reaches back into reset.
module xc_pipe_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_data
);
    logic [2:0] since_rst;

    // Saturating count of clocks since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 7) since_rst <= since_rst + 3'd1;
    end

    // R1 / R3: a response appears exactly when a request was taken five clocks earlier.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 5) |-> (rsp_valid == $past(req_valid, 5)));

    // R8: no response can appear before five clocks have passed since reset.
    assert_empty_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 5) |-> !rsp_valid);

    // R9: the outputs are quiet while no response is present.
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_data == '0));

    // R5: a miss response carries zero data.
    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
endmodule

bind ext_cache_pipe xc_pipe_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_data  (rsp_data)
);

// File: tb/ext_cache_pipe_tb.sv
// Scoreboard bench: the driver pushes predicted responses, and the monitor pops and compares them.
module ext_cache_pipe_tb;
    localparam int AW = 16;
    localparam int IW = 6;
    localparam int DW = 32;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          fill_en = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [DW-1:0] rsp_data;

    ext_cache_pipe #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model of the arrays.
    bit              m_vld [DEPTH];
    logic [AW-IW-1:0] m_tag [DEPTH];
    logic [DW-1:0]   m_data [DEPTH];

    // Scoreboard queues.
    int          q_cyc [$];
    bit          q_hit [$];
    logic [DW-1:0] q_data [$];
    string       q_req [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input string req);
        int idx = int'(a[IW-1:0]);
        bit h = m_vld[idx] && (m_tag[idx] == a[AW-1:IW]);
        req_valid = 1'b1;
        req_addr  = a;
        q_cyc.push_back(cyc + 5);
        q_hit.push_back(h);
        q_data.push_back(h ? m_data[idx] : '0);
        q_req.push_back(req);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Waits for the pipeline to drain, then writes one entry; the next clock may request it.
    task automatic fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(6);
        fill_en   = 1'b1;
        fill_addr = a;
        fill_data = d;
        m_vld[int'(a[IW-1:0])]  = 1'b1;
        m_tag[int'(a[IW-1:0])]  = a[AW-1:IW];
        m_data[int'(a[IW-1:0])] = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Monitor: compares every response with the prediction that is due in this clock.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rsp_valid) begin
                if (q_cyc.size() == 0) begin
                    report("R3", "response with no request", 64'(rsp_valid), 64'(0));
                end else begin
                    automatic int    ec = q_cyc.pop_front();
                    automatic bit    eh = q_hit.pop_front();
                    automatic logic [DW-1:0] ed = q_data.pop_front();
                    automatic string er = q_req.pop_front();
                    report("R1", "response clock", 64'(cyc), 64'(ec));
                    report(er, "hit", 64'(rsp_hit), 64'(eh));
                    report(er, "data", 64'(rsp_data), 64'(ed));
                end
            end else begin
                if (rsp_hit || rsp_data != '0)
                    report("R9", "idle outputs", {31'd0, rsp_hit, rsp_data}, 64'(0));
                if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
                    report("R1", "missing response", 64'(0), 64'(1));
                    void'(q_cyc.pop_front());
                    void'(q_hit.pop_front());
                    void'(q_data.pop_front());
                    void'(q_req.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 1'b0;
            m_tag[i] = '0;
            m_data[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R8: outputs are cleared during reset.
        report("R8", "reset outputs", {31'd0, rsp_valid, rsp_data} | 64'(rsp_hit), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R8: the first requests after reset miss; R2 back-to-back.
        for (int i = 0; i < 8; i++) issue(AW'(16'h0040 * i + i), "R8");
        idle(2);

        // R6 / R4: fill indices 0..7 with tag 1.
        for (int i = 0; i < 7; i++) fill(AW'((1 << IW) + i), 32'hA500_0000 + i);
        // R7: the last fill is requested in the very next clock.
        fill(AW'((1 << IW) + 7), 32'hA500_0007);
        issue(AW'((1 << IW) + 7), "R7");

        // R2 / R4 / R6: hits back to back.
        for (int i = 0; i < 8; i++) issue(AW'((1 << IW) + i), "R4");
        // R5: same indices, different tag.
        for (int i = 0; i < 8; i++) issue(AW'((2 << IW) + i), "R5");
        // R2: alternating hit and miss every clock.
        for (int i = 0; i < 8; i++) issue(AW'((((i % 2) + 1) << IW) + i), "R2");

        // R3: bubbles between requests.
        for (int i = 0; i < 6; i++) begin
            issue(AW'((1 << IW) + i), "R3");
            idle(i % 3 + 1);
        end

        // R10: retag index 3; the old tag misses and the new tag hits with new data.
        fill(AW'((5 << IW) + 3), 32'h5EED_0003);
        issue(AW'((5 << IW) + 3), "R10");
        issue(AW'((1 << IW) + 3), "R10");
        issue(AW'((1 << IW) + 4), "R6");

        // Boundary: highest index with an all-ones tag, then a neighbour tag.
        fill({AW{1'b1}}, 32'hFFFF_FFFE);
        issue({AW{1'b1}}, "R4");
        issue({{(AW-IW-1){1'b1}}, 1'b0, {IW{1'b1}}}, "R5");
        issue({{(AW-IW){1'b0}}, {IW{1'b1}}}, "R5");

        idle(10);
        report("R1", "all responses seen", 64'(q_cyc.size()), 64'(0));
        finish_run();
    end
endmodule